// File: doc/BRIEF.md
# Three-Wire Bus Arbitration Unit

This block decides, on behalf of a processor's bus cycle engine, who owns a shared address, data and control bus. Another device asks for the bus on a shared request line. The block answers on a grant output, and it learns that the other device has taken the bus from a shared grant acknowledge line. While the grant is pending or the bus belongs to someone else, the block tells the cycle engine not to start a new transfer. While another master holds the acknowledge line, the block raises a release output that puts the processor's bus drivers in high impedance.

All three asynchronous inputs (request, grant acknowledge and the slave's transfer acknowledge) pass through two-flop synchronizers before any logic uses them. The grant does not cut off a transfer that is already running. A requester may take over only when four things hold at once: it has been granted, no address strobe is active, no transfer acknowledge is active and nobody else drives grant acknowledge. For requester-side logic, the block reports that combined condition on a helper output. If the request goes away before any acknowledge arrives, the grant is removed and normal cycles resume.

Top module: `busarb_unit`

## Requirements
- R1: During and right after reset, busGrant is 0, busRelease is 0, ackLegal is 0 and startOk is 1.
- R2: A request held high is first sampled at a rising edge. busGrant rises at the third rising edge counting that one, whatever the state of cycleBusy.
- R3: While busGrant is 1, startOk is 0.
- R4: grantAck going high while granted raises busRelease at the second rising edge counting the first one that samples it, and drops busGrant at the third.
- R5: busRelease follows grantAck through exactly two register stages, and startOk is 0 whenever busRelease is 1.
- R6: If the request is withdrawn while granted and before any acknowledge, busGrant falls and startOk returns to 1 at the third rising edge after the withdrawal is first sampled.
- R7: ackLegal is 1 exactly when busGrant is 1, cycleBusy is 0, the synchronized transfer acknowledge is 0 and busRelease is 0.
- R8: When grantAck falls while the request is still high, busRelease falls at the second edge and busGrant comes back at the third. If the request is low by then, startOk comes back at the third edge instead.
- R9: grantAck arriving while no grant is outstanding still raises busRelease and holds startOk at 0. No grant is issued while it stays high, even if a request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busReq | input | 1 | Shared bus request (1 = another device wants the bus), asynchronous |
| grantAck | input | 1 | Shared grant acknowledge (1 = another device owns the bus), asynchronous |
| xferAck | input | 1 | Slave transfer acknowledge seen on the bus (1 = active), asynchronous |
| cycleBusy | input | 1 | From the cycle engine: 1 while its address strobe is active, synchronous |
| busGrant | output | 1 | Grant to the requester (1 = bus will be released at end of current cycle) |
| busRelease | output | 1 | 1 = float the processor's address, data and control drivers |
| startOk | output | 1 | 1 = cycle engine may begin a new bus cycle |
| ackLegal | output | 1 | Helper for requesters: 1 = asserting grant acknowledge is allowed now |

## Verification
Each result has a fixed latency, counted from the first rising edge that samples an input change. busRelease and the transfer-acknowledge part of ackLegal follow at the second edge. busGrant and startOk change at the third, because the state register sits behind the two synchronizer stages. The bench changes inputs on falling edges and samples on the falling edge after each counted rising edge. It checks both the cycle before a change is due and the cycle it lands, so an early or a late output is caught as well as a wrong one. The ackLegal decode and the grant latency are swept over every combination of cycleBusy and transfer acknowledge, and over several idle gaps before the request.

// File: rtl/busarb_pkg.sv
package busarb_pkg;
  typedef enum logic [1:0] {
    ARB_IDLE    = 2'd0,
    ARB_GRANTED = 2'd1,
    ARB_OWNED   = 2'd2
  } arbState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic grantOn;   // grant output level
    logic ownIdle;   // processor owns the bus with nothing pending
  } arbStrobes_t;
endpackage

// File: rtl/busarb_datapath.sv
module busarb_datapath
  import busarb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busReq,
  input  logic        grantAck,
  input  logic        xferAck,
  input  logic        cycleBusy,
  input  arbStrobes_t strobes,
  output logic        reqSeen,
  output logic        ackSeen,
  output logic        busGrant,
  output logic        busRelease,
  output logic        startOk,
  output logic        ackLegal
);
  localparam int NUM_IN = 3;

  logic [NUM_IN-1:0] rawIn;
  logic [NUM_IN-1:0] syncOut;
  logic              xferSeen;

  assign rawIn = {xferAck, grantAck, busReq};

  generate
    for (genvar i = 0; i < NUM_IN; i++) begin : gSync
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[SYNC_STAGES-2:0], rawIn[i]};
      end
      assign syncOut[i] = chain[SYNC_STAGES-1];
    end
  endgenerate

  assign reqSeen  = syncOut[0];
  assign ackSeen  = syncOut[1];
  assign xferSeen = syncOut[2];

  assign busGrant   = strobes.grantOn;
  assign busRelease = ackSeen;
  assign startOk    = strobes.ownIdle && !ackSeen;
  assign ackLegal   = strobes.grantOn && !cycleBusy && !xferSeen && !ackSeen;
endmodule

// File: rtl/busarb_control.sv
module busarb_control
  import busarb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqSeen,
  input  logic        ackSeen,
  output arbStrobes_t strobes
);
  arbState_t state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ARB_IDLE: begin
        if (ackSeen)      stateNext = ARB_OWNED;
        else if (reqSeen) stateNext = ARB_GRANTED;
      end
      ARB_GRANTED: begin
        if (ackSeen)       stateNext = ARB_OWNED;
        else if (!reqSeen) stateNext = ARB_IDLE;
      end
      ARB_OWNED: begin
        if (!ackSeen) stateNext = reqSeen ? ARB_GRANTED : ARB_IDLE;
      end
      default: stateNext = ARB_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ARB_IDLE;
    else       state <= stateNext;
  end

  assign strobes.grantOn = (state == ARB_GRANTED);
  assign strobes.ownIdle = (state == ARB_IDLE);
endmodule

// File: rtl/busarb_unit.sv
module busarb_unit #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic busReq,
  input  logic grantAck,
  input  logic xferAck,
  input  logic cycleBusy,
  output logic busGrant,
  output logic busRelease,
  output logic startOk,
  output logic ackLegal
);
  busarb_pkg::arbStrobes_t strobes;
  logic reqSeen;
  logic ackSeen;

  busarb_control ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .reqSeen (reqSeen),
    .ackSeen (ackSeen),
    .strobes (strobes)
  );

  busarb_datapath #(.SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .busReq     (busReq),
    .grantAck   (grantAck),
    .xferAck    (xferAck),
    .cycleBusy  (cycleBusy),
    .strobes    (strobes),
    .reqSeen    (reqSeen),
    .ackSeen    (ackSeen),
    .busGrant   (busGrant),
    .busRelease (busRelease),
    .startOk    (startOk),
    .ackLegal   (ackLegal)
  );
endmodule

// File: rtl/busarb_checker.sv
module busarb_checker #(
  parameter int SYNC_STAGES = 2
) (
  input logic clk,
  input logic rstN,
  input logic busReq,
  input logic grantAck,
  input logic cycleBusy,
  input logic busGrant,
  input logic busRelease,
  input logic startOk,
  input logic ackLegal
);
  // R3
  grant_blocks_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    busGrant |-> !startOk);

  // R5
  release_blocks_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    busRelease |-> !startOk);

  // R7
  ack_legal_cond_chk: assert property (@(posedge clk) disable iff (!rstN)
    ackLegal |-> (busGrant && !cycleBusy && !busRelease));

  // R1
  reset_outputs_chk: assert property (@(posedge clk)
    !rstN |=> (!busGrant && !busRelease));

  generate
    if (SYNC_STAGES == 2) begin : gLat
      // R2
      grant_needs_req_chk: assert property (@(posedge clk) disable iff (!rstN)
        $rose(busGrant) |-> $past(busReq, 2));
      // R4
      release_follows_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
        $rose(busRelease) |-> $past(grantAck, 1));
    end
  endgenerate
endmodule

bind busarb_unit busarb_checker #(.SYNC_STAGES(SYNC_STAGES)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .busReq     (busReq),
  .grantAck   (grantAck),
  .cycleBusy  (cycleBusy),
  .busGrant   (busGrant),
  .busRelease (busRelease),
  .startOk    (startOk),
  .ackLegal   (ackLegal)
);

// File: tb/busarb_unit_tb.sv
`timescale 1ns/1ps
module busarb_unit_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busReq = 1'b0;
  logic grantAck = 1'b0;
  logic xferAck = 1'b0;
  logic cycleBusy = 1'b0;
  logic busGrant, busRelease, startOk, ackLegal;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  busarb_unit #(.SYNC_STAGES(2)) dut_i (
    .clk(clk), .rstN(rstN), .busReq(busReq), .grantAck(grantAck),
    .xferAck(xferAck), .cycleBusy(cycleBusy), .busGrant(busGrant),
    .busRelease(busRelease), .startOk(startOk), .ackLegal(ackLegal)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  // wait n rising edges, then settle on the following falling edge
  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic goIdle();
    busReq = 0; grantAck = 0; xferAck = 0; cycleBusy = 0;
    edges(4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    edges(3);
    chk("R1 grant in reset", busGrant, 0);
    chk("R1 release in reset", busRelease, 0);
    chk("R1 startOk in reset", startOk, 1);
    rstN = 1;
    edges(1);
    chk("R1 grant after reset", busGrant, 0);
    chk("R1 ackLegal after reset", ackLegal, 0);
    chk("R1 startOk after reset", startOk, 1);

    // R2 / R3: grant latency over cycleBusy and idle gaps
    for (int cb = 0; cb < 2; cb++) begin
      for (int gap = 1; gap <= 3; gap++) begin
        edges(gap);
        cycleBusy = cb[0];
        busReq = 1;
        edges(2);
        chk("R2 grant not early", busGrant, 0);
        chk("R3 startOk before grant", startOk, 1);
        edges(1);
        chk("R2 grant on third edge", busGrant, 1);
        chk("R3 startOk blocked", startOk, 0);
        // R6: withdraw before any acknowledge
        busReq = 0;
        edges(2);
        chk("R6 grant held two edges", busGrant, 1);
        edges(1);
        chk("R6 grant removed", busGrant, 0);
        chk("R6 startOk back", startOk, 1);
        cycleBusy = 0;
      end
    end

    // R7: ackLegal sweep while granted
    busReq = 1;
    edges(3);
    for (int v = 0; v < 4; v++) begin
      cycleBusy = v[0];
      xferAck = v[1];
      edges(2);
      chk("R7 ackLegal decode", ackLegal, (v == 0));
    end
    cycleBusy = 0; xferAck = 0;
    edges(2);
    chk("R7 ackLegal granted idle bus", ackLegal, 1);

    // R4: acknowledge arrives while granted
    grantAck = 1;
    edges(1);
    chk("R4 release not early", busRelease, 0);
    edges(1);
    chk("R4 release on second edge", busRelease, 1);
    chk("R4 grant still high", busGrant, 1);
    chk("R7 ackLegal off once ack seen", ackLegal, 0);
    edges(1);
    chk("R4 grant dropped third edge", busGrant, 0);
    chk("R5 startOk low while released", startOk, 0);

    // R8: ack drops with request still high
    grantAck = 0;
    edges(2);
    chk("R8 release falls second edge", busRelease, 0);
    chk("R8 grant not yet back", busGrant, 0);
    chk("R8 startOk still low", startOk, 0);
    edges(1);
    chk("R8 grant back third edge", busGrant, 1);

    // R8: second handover, then ack drops with request gone
    grantAck = 1;
    edges(3);
    busReq = 0;
    chk("R5 release held", busRelease, 1);
    grantAck = 0;
    edges(2);
    chk("R8 startOk not early", startOk, 0);
    edges(1);
    chk("R8 idle after release", startOk, 1);
    chk("R8 no grant", busGrant, 0);

    // R9: unsolicited acknowledge, pending request blocked
    goIdle();
    grantAck = 1;
    edges(2);
    chk("R9 release without grant", busRelease, 1);
    chk("R9 startOk low", startOk, 0);
    busReq = 1;
    edges(5);
    chk("R9 no grant while owned", busGrant, 0);
    chk("R9 still released", busRelease, 1);
    grantAck = 0;
    edges(3);
    chk("R9 grant after ack drops", busGrant, 1);
    chk("R5 release gone", busRelease, 0);

    goIdle();
    chk("R1 quiet state restored", startOk, 1);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule